// File: doc/BRIEF.md
# Conditional Branch Resolver with Likely-Form Annulment

This block resolves conditional branches for a single-issue, in-order core whose branches have one delay slot. Each cycle it takes the decoded primary opcode, the two source register values, the instruction's PC and its sign-extended offset. From these it reports whether the branch is taken and which PC to fetch next. Every instruction passes through it, branch or not.

Ordinary branches always let the delay-slot instruction run. The "likely" forms behave differently when they are not taken: they cancel the delay-slot instruction and redirect fetch past it. The cancellation is held as a one-bit pending state. It is presented as a squash pulse on the next valid instruction that reaches the block, and that instruction's retirement is blocked. The branch itself always retires.

The per-form not-taken terms are OR-ed into one squash condition, so another likely form can be added by adding one term.

Top module: `brl_resolve`

## Requirements
- R1: Opcode 0x04 (equal-compare branch) is taken exactly when rs equals rt. When taken, next PC is the target. When not taken, next PC is PC+4.
- R2: Opcode 0x05 (not-equal-compare branch) is taken exactly when rs differs from rt. Next PC follows the rule of R1.
- R3: Opcode 0x14 (equal-compare likely branch) is taken exactly when rs equals rt. When taken, next PC is the target and the following instruction is not squashed.
- R4: Opcode 0x15 (not-equal-compare likely branch) is taken exactly when rs differs from rt. When taken, next PC is the target and the following instruction is not squashed.
- R5: A likely branch that is not taken drives next PC to PC+8 with taken low. The next valid instruction then sees the squash output high.
- R6: Ordinary branches (0x04, 0x05) never cause a squash, whether taken or not.
- R7: The target is PC+4 plus the offset shifted left by 2, taken modulo 2^XLEN. This holds for negative offsets and for wrap-around.
- R8: The retire-advance output is high for every valid instruction that is not squashed, including a likely branch whose slot gets squashed. It is low for a squashed instruction and for an idle cycle.
- R9: A squashed instruction has no branch effect. Taken is low, next PC is PC+4, and it schedules no squash of its own.
- R10: Any opcode other than the four branch codes gives taken low, next PC of PC+4 and no squash.
- R11: After synchronous active-low reset, no squash is pending. A reset between a likely branch and its slot cancels the pending squash.
- R12: Cycles with the valid input low leave a pending squash in place. During those cycles taken, squash and retire-advance are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | An instruction is present this cycle |
| opcode_i | input | 6 | Decoded primary opcode |
| rs_val_i | input | XLEN | First source register value |
| rt_val_i | input | XLEN | Second source register value |
| pc_i | input | XLEN | PC of the instruction |
| offset_i | input | XLEN | Sign-extended branch offset, in words |
| taken_o | output | 1 | The branch is taken |
| next_pc_o | output | XLEN | PC to fetch next |
| squash_o | output | 1 | The current instruction is annulled |
| retire_adv_o | output | 1 | The current instruction retires |

## Verification
Two functions can fall in the same cycle: annulling a delay-slot instruction, and resolving a branch that occupies that slot. The bench provokes this by placing a likely branch, whose condition would make it taken, directly in the slot of a not-taken likely branch. The expected result is that squash is high, taken is low, next PC is PC+4 and no new squash is pending afterwards. A behavioural reference model runs in parallel on directed sequences and a long mixed stream. That stream includes idle cycles between branch and slot and branches placed back to back. The model is compared on every clock.

// File: rtl/brl_pkg.sv
// Package: shared opcode codes and decode record for the branch resolver.
// Assumes a 6-bit primary opcode field.
package brl_pkg;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_BNE  = 6'h05;
    localparam logic [5:0] OPC_BEQL = 6'h14;
    localparam logic [5:0] OPC_BNEL = 6'h15;

    localparam int NUM_BR   = 4;
    localparam int IDX_BEQ  = 0;
    localparam int IDX_BNE  = 1;
    localparam int IDX_BEQL = 2;
    localparam int IDX_BNEL = 3;

    typedef struct packed {
        logic is_br;
        logic likely;
        logic on_eq;
    } br_kind_t;
endpackage

// File: rtl/brl_decode.sv
// Module: brl_decode
// Classifies a primary opcode into one-hot branch hits and a decode record
// (branch / likely / taken-on-equal). Assumes at most one code matches.
module brl_decode
    import brl_pkg::*;
(
    input  logic [5:0]        opcode_i,
    output logic [NUM_BR-1:0] hit_o,
    output br_kind_t          kind_o
);
    localparam logic [5:0] K_OPC [NUM_BR] = '{OPC_BEQ, OPC_BNE, OPC_BEQL, OPC_BNEL};
    localparam logic       K_LIK [NUM_BR] = '{1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic       K_EQ  [NUM_BR] = '{1'b1, 1'b0, 1'b1, 1'b0};

    for (genvar i = 0; i < NUM_BR; i++) begin : g_match
        assign hit_o[i] = (opcode_i == K_OPC[i]);
    end

    // Merge the matching entry's attributes into the record.
    always_comb begin
        kind_o = '0;
        for (int i = 0; i < NUM_BR; i++) begin
            if (hit_o[i]) begin
                kind_o.is_br  = 1'b1;
                kind_o.likely = K_LIK[i];
                kind_o.on_eq  = K_EQ[i];
            end
        end
    end
endmodule

// File: rtl/brl_target.sv
// Module: brl_target
// Computes the sequential successors (PC+4, PC+8) and the branch target
// (PC+4 + offset*4). All arithmetic wraps modulo 2^XLEN.
module brl_target #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] offset_i,
    output logic [XLEN-1:0] seq4_o,
    output logic [XLEN-1:0] seq8_o,
    output logic [XLEN-1:0] target_o
);
    localparam logic [XLEN-1:0] STEP4 = XLEN'(4);
    localparam logic [XLEN-1:0] STEP8 = XLEN'(8);

    logic [XLEN-1:0] byte_off;

    // Scale the word offset to bytes and form the successors.
    always_comb begin
        byte_off = offset_i << 2;
        seq4_o   = pc_i + STEP4;
        seq8_o   = pc_i + STEP8;
        target_o = seq4_o + byte_off;
    end
endmodule

// File: rtl/brl_resolve.sv
// Module: brl_resolve (top)
// Resolves ordinary and likely conditional branches. A likely branch that
// is not taken skips its delay slot (next PC = PC+8) and marks a pending
// squash. That squash is applied to the next valid instruction: the
// instruction gets no branch effect and does not retire. Assumes every
// instruction passes through in program order and that the slot follows
// its branch as the next valid input.
module brl_resolve
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid_i,
    input  logic [5:0]      opcode_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] offset_i,
    output logic            taken_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic            squash_o,
    output logic            retire_adv_o
);
    logic [NUM_BR-1:0] hit;
    br_kind_t          kind;
    logic [XLEN-1:0]   seq4, seq8, target;
    logic              pend_q;
    logic              live;
    logic              ops_eq;
    logic              cond_met;
    logic              squash_now;

    brl_decode u_dec (
        .opcode_i (opcode_i),
        .hit_o    (hit),
        .kind_o   (kind)
    );

    brl_target #(.XLEN(XLEN)) u_tgt (
        .pc_i     (pc_i),
        .offset_i (offset_i),
        .seq4_o   (seq4),
        .seq8_o   (seq8),
        .target_o (target)
    );

    // Evaluate the condition for the live (not annulled) instruction.
    always_comb begin
        live     = in_valid_i && !pend_q;
        ops_eq   = (rs_val_i == rt_val_i);
        cond_met = kind.on_eq ? ops_eq : !ops_eq;
        taken_o  = live && kind.is_br && cond_met;
    end

    // Likely forms squash on their not-taken condition; extend by OR-ing terms.
    always_comb begin
        squash_now = live && ((hit[IDX_BEQL] && !ops_eq)
                           || (hit[IDX_BNEL] &&  ops_eq));
    end

    // Select the next fetch address.
    always_comb begin
        if (taken_o)         next_pc_o = target;
        else if (squash_now) next_pc_o = seq8;
        else                 next_pc_o = seq4;
    end

    // Hold a pending squash until the next valid instruction consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (in_valid_i) pend_q <= squash_now;
    end

    // Annul and retire indications for the current instruction.
    always_comb begin
        squash_o     = in_valid_i &&  pend_q;
        retire_adv_o = in_valid_i && !pend_q;
    end
endmodule

// File: rtl/brl_resolve_chk.sv
// Module: brl_resolve_chk
// Property checker for brl_resolve, attached by bind. Observes the ports
// and the pending-squash state.
module brl_resolve_chk
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid_i,
    input logic [5:0]      opcode_i,
    input logic [XLEN-1:0] rs_val_i,
    input logic [XLEN-1:0] rt_val_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] offset_i,
    input logic            taken_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            squash_o,
    input logic            retire_adv_o,
    input logic            pend_q
);
    logic live_c;
    assign live_c = in_valid_i && !squash_o;

    assert_skip_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_c && ((opcode_i == OPC_BNEL && rs_val_i == rt_val_i)
                 || (opcode_i == OPC_BEQL && rs_val_i != rt_val_i)))
        |-> (!taken_o && next_pc_o == pc_i + XLEN'(8)));

    assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_c && ((opcode_i == OPC_BNEL && rs_val_i == rt_val_i)
                 || (opcode_i == OPC_BEQL && rs_val_i != rt_val_i)))
        |=> pend_q);

    assert_plain_no_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (opcode_i == OPC_BEQ || opcode_i == OPC_BNE)) |=> !pend_q);

    assert_bnel_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_c && opcode_i == OPC_BNEL && rs_val_i != rt_val_i)
        |-> (taken_o && next_pc_o == pc_i + XLEN'(4) + (offset_i << 2)));

    assert_slot_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> (!taken_o && next_pc_o == pc_i + XLEN'(4)));

    assert_no_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> !retire_adv_o);

    assert_retire_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live_c |-> retire_adv_o);

    assert_bubble_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(pend_q));
endmodule

bind brl_resolve brl_resolve_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (in_valid_i),
    .opcode_i     (opcode_i),
    .rs_val_i     (rs_val_i),
    .rt_val_i     (rt_val_i),
    .pc_i         (pc_i),
    .offset_i     (offset_i),
    .taken_o      (taken_o),
    .next_pc_o    (next_pc_o),
    .squash_o     (squash_o),
    .retire_adv_o (retire_adv_o),
    .pend_q       (pend_q)
);

// File: tb/brl_resolve_tb.sv
// Bench for brl_resolve: behavioural reference model compared every clock.
module brl_resolve_tb;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid_i = 1'b0;
    logic [5:0]      opcode_i = '0;
    logic [XLEN-1:0] rs_val_i = '0, rt_val_i = '0, pc_i = '0, offset_i = '0;
    logic            taken_o, squash_o, retire_adv_o;
    logic [XLEN-1:0] next_pc_o;

    int  vectors = 0;
    int  fails   = 0;
    bit  m_pend  = 1'b0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    brl_resolve #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .opcode_i(opcode_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .pc_i(pc_i), .offset_i(offset_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .squash_o(squash_o),
        .retire_adv_o(retire_adv_o)
    );

    task automatic chk1(input string tag, input string what, input logic act, input logic exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [5:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] pc,
                        input logic [31:0] off, input string tag);
        bit eq, br, cond, tk, lnt, live;
        logic [31:0] exp_pc;
        @(negedge clk);
        in_valid_i = v; opcode_i = op; rs_val_i = a; rt_val_i = b;
        pc_i = pc; offset_i = off;
        #1;
        live = v && !m_pend;
        eq   = (a == b);
        br   = (op == 6'h04) || (op == 6'h05) || (op == 6'h14) || (op == 6'h15);
        cond = (op == 6'h04 || op == 6'h14) ? eq : !eq;
        tk   = live && br && cond;
        lnt  = live && ((op == 6'h14 && !eq) || (op == 6'h15 && eq));
        exp_pc = tk ? pc + 32'd4 + (off * 32'd4) : (lnt ? pc + 32'd8 : pc + 32'd4);
        vectors++;
        chk1(tag, "taken", taken_o, tk);
        chk1(tag, "squash", squash_o, v && m_pend);
        chk1(tag, "retire", retire_adv_o, live);
        if (next_pc_o !== exp_pc) begin
            fails++;
            $display("FAIL %s next_pc actual=%h expected=%h", tag, next_pc_o, exp_pc);
        end
        @(posedge clk);
        if (v) m_pend = lnt;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid_i = 1'b0;
        @(posedge clk);
        m_pend = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R11: clean state after reset
        step(1, 6'h00, 1, 1, 32'h100, 0, "R11");
        // R1: equal-compare branch
        step(1, 6'h04, 7, 7, 32'h200, 32'h10, "R1");
        step(1, 6'h00, 0, 0, 32'h244, 0, "R6");
        step(1, 6'h04, 7, 8, 32'h300, 32'h10, "R1");
        step(1, 6'h00, 0, 0, 32'h304, 0, "R6");
        // R2: not-equal branch; slot executes on equal operands
        step(1, 6'h05, 5, 9, 32'h400, 32'h3, "R2");
        step(1, 6'h00, 0, 0, 32'h404, 0, "R6");
        step(1, 6'h05, 3, 3, 32'h500, 32'h3, "R2");
        step(1, 6'h00, 0, 0, 32'h504, 0, "R6");
        // R3, R4: likely forms taken, slot kept
        step(1, 6'h14, 9, 9, 32'h600, 32'h20, "R3");
        step(1, 6'h00, 0, 0, 32'h604, 0, "R3");
        step(1, 6'h15, 5, 7, 32'h700, 32'h20, "R4");
        step(1, 6'h00, 0, 0, 32'h704, 0, "R4");
        // R5, R8: likely not taken, slot squashed, branch retires
        step(1, 6'h15, 3, 3, 32'h800, 32'h20, "R5");
        step(1, 6'h00, 0, 0, 32'h804, 0, "R8");
        step(1, 6'h00, 0, 0, 32'h808, 0, "R8");
        step(1, 6'h14, 1, 2, 32'h900, 32'h20, "R5");
        step(1, 6'h00, 0, 0, 32'h904, 0, "R5");
        // R7: negative offset and wrap
        step(1, 6'h04, 4, 4, 32'h1000, 32'hFFFF_FFFC, "R7");
        step(1, 6'h00, 0, 0, 32'h1004, 0, "R7");
        step(1, 6'h05, 1, 2, 32'hFFFF_FFF8, 32'h4, "R7");
        step(1, 6'h00, 0, 0, 32'hFFFF_FFFC, 0, "R7");
        // R9: branch sitting in a squashed slot has no effect
        step(1, 6'h15, 6, 6, 32'h1100, 32'h8, "R9");
        step(1, 6'h14, 2, 2, 32'h1104, 32'h8, "R9");
        step(1, 6'h00, 0, 0, 32'h1108, 0, "R9");
        // R10: other opcodes
        step(1, 6'h16, 2, 2, 32'h1200, 32'h8, "R10");
        step(1, 6'h02, 2, 3, 32'h1204, 32'h8, "R10");
        // R12: bubbles between branch and slot
        step(1, 6'h15, 4, 4, 32'h1300, 32'h8, "R12");
        step(0, 6'h04, 1, 1, 32'h1304, 32'h8, "R12");
        step(0, 6'h00, 0, 0, 32'h1304, 0, "R12");
        step(1, 6'h05, 1, 2, 32'h1304, 32'h8, "R12");
        step(1, 6'h00, 0, 0, 32'h1308, 0, "R12");
        // R11: reset cancels a pending squash
        step(1, 6'h14, 1, 2, 32'h1400, 32'h8, "R11");
        pulse_reset();
        step(1, 6'h00, 0, 0, 32'h1404, 0, "R11");
        // Mixed stream
        for (int i = 0; i < 800; i++) begin
            logic [5:0] op;
            logic [31:0] a, b;
            int sel;
            sel = int'($urandom_range(0, 5));
            op = (sel == 0) ? 6'h04 : (sel == 1) ? 6'h05 : (sel == 2) ? 6'h14 :
                 (sel == 3) ? 6'h15 : (sel == 4) ? 6'h00 : 6'h16;
            a = $urandom; b = ($urandom_range(0, 1) == 1) ? a : $urandom;
            step($urandom_range(0, 6) != 0, op, a, b, $urandom, $urandom, "mix");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule